// File: doc/BRIEF.md
# Clock Root Configuration Front End

This block is the software-facing control point for one clock root. Software reaches it through a plain synchronous register port (address, write data, write enable, read data). A command word holds the update request, a force-on control, per-register dirty flags and a read-only "root off" status. A configuration word and three fractional-divider words (M, N, D) are kept in shadow storage. Values written there have no effect on the clock datapath until software requests an update.

An update request starts a fixed-length wait that stands for the glitch-free switchover point. At the end of that wait the shadow values are copied into active storage in one cycle, a one-cycle load strobe is raised, the dirty flags are cleared and the request bit clears itself. The active values drive the divider and multiplexer datapath, which lies outside this block. The active source code is also given as a one-hot select, and a dual-edge indication is raised for the fractional mode. The root counts as running when force-on is set or the downstream enable request is high.

The register port carries no data stream: it is a single-cycle access with no back-pressure. A write takes effect at the clock edge where `we_i` is high. Read data is a combinational function of `addr_i`.

Top module: `crcfg_root_ctrl`

## Requirements
- R1: After reset the command word (address 0) reads 0x8000_0000. The configuration word (address 1), M (address 2), N (address 3) and D (address 4) read 0. All active outputs are 0 and `root_on_o` is 0.
- R2: Writes to addresses 1..4 land in shadow storage, and reads of those addresses return the shadow value. The configuration word keeps only the pre-divider at bits DIV_W-1:0, the source code at bits 10:8 and the mode at bits 13:12, and every other bit reads 0. M, N and D keep bits MND_W-1:0. Active outputs do not change on these writes.
- R3: Writing the command word with bit 0 = 1 sets bit 0, and bit 0 reads 1 for exactly UPD_LAT cycles and then clears. In the last of those cycles `cfg_load_o` is 1. At the clearing edge every active output takes the shadow value.
- R4: Writing bit 0 = 1 while an update is pending neither restarts nor extends the wait.
- R5: Command bits 4, 5, 6 and 7 are the dirty flags of configuration, N, M and D. A write to a shadow word sets its flag to (new value differs from the active value), and update completion clears all flags.
- R6: Command bit 1 is a read/write force-on control. `root_on_o` equals (force-on OR `root_req_i`) delayed by one clock, and command bit 31 reads the inverse of `root_on_o`.
- R7: `dual_edge_o` is 1 exactly when the active mode is 2. `act_src_oh_o` has exactly one bit set, at the index given by the active source code.
- R8: Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 32 | Read data for `addr_i` |
| root_req_i | input | 1 | Downstream request to run the root |
| root_on_o | output | 1 | Root running |
| act_div_o | output | DIV_W | Active pre-divider |
| act_src_o | output | 3 | Active source code |
| act_src_oh_o | output | 8 | Active source, one-hot |
| act_mode_o | output | 2 | Active mode |
| dual_edge_o | output | 1 | Active mode is dual-edge |
| act_m_o | output | MND_W | Active M |
| act_n_o | output | MND_W | Active N |
| act_d_o | output | MND_W | Active D |
| cfg_load_o | output | 1 | One-cycle strobe in the cycle the active values are loaded |

## Verification
If the shadow and active copies were mixed up, a configuration readback would differ from what was written, or the active outputs would move before the load strobe. Either shows on the first access after the write. A wrong wait counter shows as bit 0 clearing one or more cycles early or late. A dirty flag computed against the wrong reference shows on the next command read. A lost or extra register stage on the root status moves `root_on_o` and bit 31 by a cycle, which the first force or request toggle exposes.

// File: rtl/crcfg_pkg.sv
package crcfg_pkg;
  localparam int A_CMD = 0;
  localparam int A_CFG = 1;
  localparam int A_M   = 2;
  localparam int A_N   = 3;
  localparam int A_D   = 4;

  localparam int SRC_W    = 3;
  localparam int NUM_SRC  = 1 << SRC_W;
  localparam int MODE_W   = 2;
  localparam int SRC_LSB  = 8;
  localparam int MODE_LSB = 12;
  localparam logic [MODE_W-1:0] MODE_DUAL = 2'd2;

  localparam int C_REQ   = 0;
  localparam int C_FORCE = 1;
  localparam int C_DCFG  = 4;
  localparam int C_DN    = 5;
  localparam int C_DM    = 6;
  localparam int C_DD    = 7;
  localparam int C_OFF   = 31;

  // index of M, N, D inside the shadow arrays
  localparam int IX_M = 0;
  localparam int IX_N = 1;
  localparam int IX_D = 2;
endpackage

// File: rtl/crcfg_update_seq.sv
module crcfg_update_seq #(
  parameter int UPD_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pend_o,
  output logic commit_o
);
  localparam int CNT_W = (UPD_LAT > 1) ? $clog2(UPD_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_LAT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign commit_o = pend_q && (cnt_q == LAST);
  assign pend_o   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (cnt_q == LAST) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (req_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && req_i) |=> pend_q);
  assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !pend_q);
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !commit_o) |=> (pend_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/crcfg_shadow_regs.sv
module crcfg_shadow_regs
  import crcfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cfg_i,
  input  logic [2:0]           wr_mnd_i,
  input  logic [31:0]          wdata_i,
  input  logic                 commit_i,
  output logic [DIV_W-1:0]     sh_div_o,
  output logic [SRC_W-1:0]     sh_src_o,
  output logic [MODE_W-1:0]    sh_mode_o,
  output logic [DIV_W-1:0]     act_div_o,
  output logic [SRC_W-1:0]     act_src_o,
  output logic [MODE_W-1:0]    act_mode_o,
  output logic [2:0][MND_W-1:0] sh_mnd_o,
  output logic [2:0][MND_W-1:0] act_mnd_o,
  output logic                 dirty_cfg_o,
  output logic [2:0]           dirty_mnd_o
);
  localparam int CFG_W = DIV_W + SRC_W + MODE_W;

  logic [CFG_W-1:0] new_cfg, sh_cfg_q, act_cfg_q, ref_cfg;

  assign new_cfg = {wdata_i[MODE_LSB +: MODE_W], wdata_i[SRC_LSB +: SRC_W],
                    wdata_i[DIV_W-1:0]};
  // a write that meets a commit compares with the value about to become active
  assign ref_cfg = commit_i ? sh_cfg_q : act_cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cfg_q    <= '0;
      act_cfg_q   <= '0;
      dirty_cfg_o <= 1'b0;
    end else begin
      if (commit_i) act_cfg_q <= sh_cfg_q;
      if (wr_cfg_i) begin
        sh_cfg_q    <= new_cfg;
        dirty_cfg_o <= (new_cfg != ref_cfg);
      end else if (commit_i) begin
        dirty_cfg_o <= 1'b0;
      end
    end
  end

  assign {sh_mode_o, sh_src_o, sh_div_o}    = sh_cfg_q;
  assign {act_mode_o, act_src_o, act_div_o} = act_cfg_q;

  for (genvar g = 0; g < 3; g++) begin : g_mnd
    logic [MND_W-1:0] sh_q, act_q, nv, rv;
    logic             dty_q;
    assign nv = wdata_i[MND_W-1:0];
    assign rv = commit_i ? sh_q : act_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
        dty_q <= 1'b0;
      end else begin
        if (commit_i) act_q <= sh_q;
        if (wr_mnd_i[g]) begin
          sh_q  <= nv;
          dty_q <= (nv != rv);
        end else if (commit_i) begin
          dty_q <= 1'b0;
        end
      end
    end
    assign sh_mnd_o[g]    = sh_q;
    assign act_mnd_o[g]   = act_q;
    assign dirty_mnd_o[g] = dty_q;
  end

  assert_dirty_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wr_cfg_i && wr_mnd_i == 3'b000) |=> (!dirty_cfg_o && dirty_mnd_o == 3'b000));
  assert_act_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_cfg_q));
endmodule

// File: rtl/crcfg_src_decode.sv
module crcfg_src_decode #(
  parameter int SRC_W   = 3,
  parameter int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   src_i,
  output logic [NUM_SRC-1:0] oh_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign oh_o[i] = (src_i == SRC_W'(i));
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oh_o) == 1);
endmodule

// File: rtl/crcfg_root_status.sv
module crcfg_root_status (
  input  logic clk,
  input  logic rst_n,
  input  logic force_i,
  input  logic req_i,
  output logic on_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) on_o <= 1'b0;
    else        on_o <= force_i | req_i;
  end

  assert_force_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> on_o);
  assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !req_i) |=> !on_o);
endmodule

// File: rtl/crcfg_root_ctrl.sv
module crcfg_root_ctrl
  import crcfg_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DIV_W   = 5,
  parameter int MND_W   = 8,
  parameter int UPD_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  output logic [31:0]        rdata_o,
  input  logic               root_req_i,
  output logic               root_on_o,
  output logic [DIV_W-1:0]   act_div_o,
  output logic [2:0]         act_src_o,
  output logic [7:0]         act_src_oh_o,
  output logic [1:0]         act_mode_o,
  output logic               dual_edge_o,
  output logic [MND_W-1:0]   act_m_o,
  output logic [MND_W-1:0]   act_n_o,
  output logic [MND_W-1:0]   act_d_o,
  output logic               cfg_load_o
);
  logic wr_cmd, wr_cfg;
  logic [2:0] wr_mnd;
  logic force_q, pend, commit, dirty_cfg;
  logic [2:0] dirty_mnd;
  logic [DIV_W-1:0] sh_div;
  logic [SRC_W-1:0] sh_src;
  logic [MODE_W-1:0] sh_mode;
  logic [2:0][MND_W-1:0] sh_mnd, act_mnd;

  assign wr_cmd       = we_i && (addr_i == ADDR_W'(A_CMD));
  assign wr_cfg       = we_i && (addr_i == ADDR_W'(A_CFG));
  assign wr_mnd[IX_M] = we_i && (addr_i == ADDR_W'(A_M));
  assign wr_mnd[IX_N] = we_i && (addr_i == ADDR_W'(A_N));
  assign wr_mnd[IX_D] = we_i && (addr_i == ADDR_W'(A_D));

  always_ff @(posedge clk) begin
    if (!rst_n)      force_q <= 1'b0;
    else if (wr_cmd) force_q <= wdata_i[C_FORCE];
  end

  crcfg_update_seq #(.UPD_LAT(UPD_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(wr_cmd && wdata_i[C_REQ]),
    .pend_o(pend), .commit_o(commit));

  crcfg_shadow_regs #(.DIV_W(DIV_W), .MND_W(MND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_cfg_i(wr_cfg), .wr_mnd_i(wr_mnd),
    .wdata_i(wdata_i), .commit_i(commit),
    .sh_div_o(sh_div), .sh_src_o(sh_src), .sh_mode_o(sh_mode),
    .act_div_o(act_div_o), .act_src_o(act_src_o), .act_mode_o(act_mode_o),
    .sh_mnd_o(sh_mnd), .act_mnd_o(act_mnd),
    .dirty_cfg_o(dirty_cfg), .dirty_mnd_o(dirty_mnd));

  crcfg_src_decode #(.SRC_W(SRC_W), .NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .src_i(act_src_o), .oh_o(act_src_oh_o));

  crcfg_root_status u_stat (
    .clk(clk), .rst_n(rst_n), .force_i(force_q), .req_i(root_req_i),
    .on_o(root_on_o));

  assign act_m_o     = act_mnd[IX_M];
  assign act_n_o     = act_mnd[IX_N];
  assign act_d_o     = act_mnd[IX_D];
  assign dual_edge_o = (act_mode_o == MODE_DUAL);
  assign cfg_load_o  = commit;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CMD): begin
        rdata_o[C_REQ]   = pend;
        rdata_o[C_FORCE] = force_q;
        rdata_o[C_DCFG]  = dirty_cfg;
        rdata_o[C_DN]    = dirty_mnd[IX_N];
        rdata_o[C_DM]    = dirty_mnd[IX_M];
        rdata_o[C_DD]    = dirty_mnd[IX_D];
        rdata_o[C_OFF]   = ~root_on_o;
      end
      ADDR_W'(A_CFG): begin
        rdata_o[DIV_W-1:0]             = sh_div;
        rdata_o[SRC_LSB +: SRC_W]      = sh_src;
        rdata_o[MODE_LSB +: MODE_W]    = sh_mode;
      end
      ADDR_W'(A_M): rdata_o[MND_W-1:0] = sh_mnd[IX_M];
      ADDR_W'(A_N): rdata_o[MND_W-1:0] = sh_mnd[IX_N];
      ADDR_W'(A_D): rdata_o[MND_W-1:0] = sh_mnd[IX_D];
      default: rdata_o = '0;
    endcase
  end

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_o |=> ({act_mode_o, act_src_o, act_div_o} == $past({sh_mode, sh_src, sh_div})
                    && act_m_o == $past(sh_mnd[IX_M]) && act_d_o == $past(sh_mnd[IX_D])));
  assert_req_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(cfg_load_o));
  assert_stable_wo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_o |=> ($stable(act_m_o) && $stable(act_n_o) && $stable(act_d_o)));
endmodule

// File: tb/crcfg_root_ctrl_tb_top.sv
module crcfg_root_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;
  localparam int UPD_LAT = 4;
  localparam logic [31:0] CFG_MASK = 32'h0000_3700 | ((32'd1 << DIV_W) - 1);
  localparam logic [31:0] MND_MASK = (32'd1 << MND_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, root_req = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic root_on, dual_edge, cfg_load;
  logic [DIV_W-1:0] act_div;
  logic [2:0] act_src;
  logic [7:0] act_oh;
  logic [1:0] act_mode;
  logic [MND_W-1:0] act_m, act_n, act_d;

  int checks = 0, errors = 0;
  bit done = 0;
  // model: index 1 cfg, 2 M, 3 N, 4 D
  logic [31:0] m_sh [1:4];
  logic [31:0] m_act [1:4];
  logic        m_dty [1:4];

  always #(CLK_PERIOD/2) clk = ~clk;

  crcfg_root_ctrl #(.ADDR_W(3), .DIV_W(DIV_W), .MND_W(MND_W), .UPD_LAT(UPD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .root_req_i(root_req), .root_on_o(root_on),
    .act_div_o(act_div), .act_src_o(act_src), .act_src_oh_o(act_oh),
    .act_mode_o(act_mode), .dual_edge_o(dual_edge), .act_m_o(act_m),
    .act_n_o(act_n), .act_d_o(act_d), .cfg_load_o(cfg_load));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] act_word(input int r);
    case (r)
      1: return 32'(act_div) | (32'(act_src) << 8) | (32'(act_mode) << 12);
      2: return 32'(act_m);
      3: return 32'(act_n);
      default: return 32'(act_d);
    endcase
  endfunction

  function automatic logic [3:0] exp_dirty();
    return {m_dty[4], m_dty[2], m_dty[3], m_dty[1]}; // bits 7..4: D, M, N, cfg
  endfunction

  task automatic shadow_write(input int r, input logic [31:0] v);
    logic [31:0] mv;
    mv = v & ((r == 1) ? CFG_MASK : MND_MASK);
    wr(3'(r), v);
    m_sh[r] = mv;
    m_dty[r] = (mv != m_act[r]);
  endtask

  task automatic run_update();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    rd(3'd0, d);
    chk("R3 request bit set", 32'(d[0]), 32'd1);
    for (int r = 1; r <= 4; r++) chk("R2 active held before load", act_word(r), m_act[r]);
    repeat (UPD_LAT - 1) @(negedge clk);
    rd(3'd0, d);
    chk("R3 still pending last cycle", 32'(d[0]), 32'd1);
    chk("R3 load strobe", 32'(cfg_load), 32'd1);
    @(negedge clk);
    rd(3'd0, d);
    chk("R3 request self-cleared", 32'(d[0]), 32'd0);
    chk("R5 dirty cleared", 32'(d[7:4]), 32'd0);
    chk("R3 strobe low", 32'(cfg_load), 32'd0);
    for (int r = 1; r <= 4; r++) begin
      m_act[r] = m_sh[r];
      m_dty[r] = 1'b0;
      chk("R3 active loaded", act_word(r), m_act[r]);
    end
    chk("R7 dual edge", 32'(dual_edge), 32'(act_mode == 2'd2));
    chk("R7 one-hot source", 32'(act_oh), 32'd1 << act_src);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int r = 1; r <= 4; r++) begin m_sh[r] = 0; m_act[r] = 0; m_dty[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, d); chk("R1 command reset", d, 32'h8000_0000);
    for (int r = 1; r <= 4; r++) begin
      rd(3'(r), d); chk("R1 shadow reset", d, 32'd0);
      chk("R1 active reset", act_word(r), 32'd0);
    end
    chk("R1 root off", 32'(root_on), 32'd0);

    // R2 masking, R5 flag positions
    shadow_write(1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R2 cfg masked readback", d, CFG_MASK);
    shadow_write(3, 32'h1234_56A5);
    rd(3'd3, d); chk("R2 N masked readback", d, 32'hA5);
    rd(3'd0, d); chk("R5 dirty flags cfg,N", 32'(d[7:4]), 32'(exp_dirty()));
    shadow_write(3, 32'h0);
    rd(3'd0, d); chk("R5 write equal to active clears flag", 32'(d[7:4]), 32'(exp_dirty()));
    // R8 undefined addresses
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'h0);
    rd(3'd6, d); chk("R8 undefined reads zero", d, 32'd0);
    rd(3'd1, d); chk("R8 cfg untouched", d, m_sh[1]);
    rd(3'd0, d); chk("R8 dirty untouched", 32'(d[7:4]), 32'(exp_dirty()));
    run_update();

    // R4: second request while pending
    shadow_write(2, 32'h77);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h1);
    @(negedge clk);
    rd(3'd0, d); chk("R4 pending at original last cycle", 32'(d[0]), 32'd1);
    @(negedge clk);
    rd(3'd0, d); chk("R4 cleared on original schedule", 32'(d[0]), 32'd0);
    chk("R4 M loaded", 32'(act_m), 32'h77);
    m_act[2] = 32'h77; m_dty[2] = 0;

    // R6 force and external request latency
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R6 force bit reads back", 32'(d[1]), 32'd1);
    chk("R6 root not yet on", 32'(root_on), 32'd0);
    @(negedge clk);
    rd(3'd0, d); chk("R6 root on after one cycle", 32'(root_on), 32'd1);
    chk("R6 off status low", 32'(d[31]), 32'd0);
    wr(3'd0, 32'h0);
    chk("R6 still on one cycle", 32'(root_on), 32'd1);
    @(negedge clk);
    rd(3'd0, d); chk("R6 off status high", 32'(d[31]), 32'd1);
    root_req = 1'b1;
    @(negedge clk); chk("R6 request turns root on", 32'(root_on), 32'd1);
    root_req = 1'b0;
    @(negedge clk); chk("R6 request drop turns off", 32'(root_on), 32'd0);

    // directed dual-edge mode
    shadow_write(1, 32'h0000_2503);
    run_update();
    chk("R7 mode 2 gives dual edge", 32'(dual_edge), 32'd1);

    // random shadow traffic with periodic updates
    for (int it = 0; it < 60; it++) begin
      int r;
      logic [31:0] v;
      r = 1 + int'($urandom_range(3));
      v = ($urandom_range(3) == 0) ? m_act[r] : $urandom;
      shadow_write(r, v);
      rd(3'(r), d); chk("R2 random readback", d, m_sh[r]);
      rd(3'd0, d); chk("R5 random dirty", 32'(d[7:4]), 32'(exp_dirty()));
      chk("R2 active unchanged", act_word(r), m_act[r]);
      if (it % 7 == 6) run_update();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule